// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus (SCL clock line, SDA data line, both open-drain with external pull-ups). After a protocol interruption, a loss of power or a system reset, a target on the bus may still be in the middle of a byte and may be holding SDA low. A one-cycle request on `start_req` makes the block play a fixed recovery waveform. The waveform is a start condition, nine dummy SCL clocks with SDA released, a second start condition and then a stop condition. The bus is then left released and idle, ready for a normal transfer.

The block never drives a line high. Each output is a pull-low enable: 1 pulls the line low and 0 releases it so the pull-up takes it high. Every waveform phase lasts `HALF_PERIOD` system clocks, which is one SCL half-period. `busy` covers the whole sequence. A single-cycle `done` marks its end. The reset is synchronous and active low.

Top module: `bus_recovery_seq`

## Requirements
- R1: While `rst_n` is low, and while idle, `scl_pull` and `sda_pull` are 0 (released), `busy` is 0 and `done` is 0.
- R2: A `start_req` sampled high while idle sets `busy` from the next cycle. The first half-period of the sequence keeps both lines released.
- R3: The first start condition pulls SDA low (`sda_pull`=1) with SCL released for one half-period. SCL is then pulled low with SDA still low for one half-period.
- R4: Nine dummy clocks follow. Each is one half-period with SCL pulled low and then one half-period with SCL released, and SDA stays released throughout. Every phase lasts exactly `HALF_PERIOD` cycles.
- R5: `scl_pull` and `sda_pull` never change in the same cycle. Once either line changes, neither line changes again for at least `HALF_PERIOD` cycles.
- R6: After the high half of the ninth clock, SDA is pulled low while SCL stays released (the second start). This lasts one half-period.
- R7: SDA is then released while SCL stays released (the stop). Both lines stay released for one half-period and afterwards.
- R8: `done` is high for exactly one cycle: the cycle right after the stop half-period. `busy` is 0 in that cycle, so `busy` lasts exactly 23 half-periods.
- R9: A `start_req` sampled while `busy` is high has no effect on the waveform or on the timing of `done`. It does not queue a later sequence.
- R10: Pulling `rst_n` low in the middle of a sequence returns the block to idle at the next clock edge, with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Single-cycle request to run the recovery sequence |
| busy | output | 1 | High while the recovery sequence runs |
| done | output | 1 | One-cycle pulse when the stop has completed |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the ports is a request that arrives while the sequence is already running. This matters most in the very last busy cycle, where a request sampled on the edge that returns the block to idle could be wrongly taken as a new start. The bench replays the full waveform with requests placed inside the first start, in the middle of the dummy clocks and in the final stop cycle. It compares every cycle against the phase table and then confirms that `busy` stays low after `done`. A reset asserted in the middle of the dummy clocks is also applied, followed by a clean rerun.

// File: rtl/busrec_pkg.sv
`timescale 1ns/1ps
// Package busrec_pkg
// Shared state type and line-drive decode for the bus recovery sequencer.
// Assumes lines are open-drain: a drive value of 1 pulls low, 0 releases.
package busrec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_START1,
        ST_HOLD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_START2,
        ST_STOP
    } rec_state_e;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } line_drive_t;

    // Map a sequencer state to the pull-low enables of both lines.
    function automatic line_drive_t drive_for(rec_state_e s);
        line_drive_t d;
        case (s)
            ST_START1: d = '{scl_pull: 1'b0, sda_pull: 1'b1};
            ST_HOLD:   d = '{scl_pull: 1'b1, sda_pull: 1'b1};
            ST_CLK_LO: d = '{scl_pull: 1'b1, sda_pull: 1'b0};
            ST_START2: d = '{scl_pull: 1'b0, sda_pull: 1'b1};
            default:   d = '{scl_pull: 1'b0, sda_pull: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/half_timer.sv
`timescale 1ns/1ps
// Module half_timer
// Counts system clocks while run is high and pulses tick on the last cycle
// of every half-period. Assumes HALF_PERIOD >= 2. The count is held at zero
// while run is low, so the first phase after run rises is full length.
module half_timer #(
    parameter int HALF_PERIOD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_PERIOD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag the final cycle of the current half-period.
    assign tick = run && (cnt_q == LAST);

    // Advance the count, restarting on each tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/recovery_fsm.sv
`timescale 1ns/1ps
// Module recovery_fsm
// Steps through the recovery phases, one phase per timer tick: pre-idle,
// start, hold, NUM_CLOCKS low/high clock pairs, second start, stop.
// Exposes the next state so that the line register can align with it.
// Assumes start_req is only acted on in ST_IDLE.
module recovery_fsm
    import busrec_pkg::*;
#(
    parameter int NUM_CLOCKS = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       tick,
    output rec_state_e state_q,
    output rec_state_e state_d,
    output logic       done
);
    localparam int CLK_W = $clog2(NUM_CLOCKS + 1);
    localparam logic [CLK_W-1:0] LAST_CLK = CLK_W'(NUM_CLOCKS - 1);

    logic [CLK_W-1:0] clk_cnt_q;
    logic [CLK_W-1:0] clk_cnt_d;

    // Choose the next phase and the next dummy-clock count.
    always_comb begin
        state_d   = state_q;
        clk_cnt_d = clk_cnt_q;
        case (state_q)
            ST_IDLE: begin
                clk_cnt_d = '0;
                if (start_req) state_d = ST_PRE;
            end
            ST_PRE:    if (tick) state_d = ST_START1;
            ST_START1: if (tick) state_d = ST_HOLD;
            ST_HOLD:   if (tick) state_d = ST_CLK_LO;
            ST_CLK_LO: if (tick) state_d = ST_CLK_HI;
            ST_CLK_HI: begin
                if (tick) begin
                    if (clk_cnt_q == LAST_CLK) begin
                        state_d = ST_START2;
                    end else begin
                        clk_cnt_d = clk_cnt_q + 1'b1;
                        state_d   = ST_CLK_LO;
                    end
                end
            end
            ST_START2: if (tick) state_d = ST_STOP;
            ST_STOP:   if (tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Register the phase, the clock count and the end-of-sequence pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            clk_cnt_q <= '0;
            done      <= 1'b0;
        end else begin
            state_q   <= state_d;
            clk_cnt_q <= clk_cnt_d;
            done      <= (state_q == ST_STOP) && tick;
        end
    end
endmodule

// File: rtl/line_driver.sv
`timescale 1ns/1ps
// Module line_driver
// Registers the pull-low enables for SCL and SDA from the next sequencer
// state, so that the pins come straight from flops and change on the same
// edge as the state. Assumes a released line is pulled high externally.
module line_driver
    import busrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rec_state_e state_d,
    output logic       scl_pull,
    output logic       sda_pull
);
    line_drive_t drv_q;

    // Capture the decoded drive for the upcoming phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drive_for(state_d);
        end
    end

    assign scl_pull = drv_q.scl_pull;
    assign sda_pull = drv_q.sda_pull;
endmodule

// File: rtl/bus_recovery_seq.sv
`timescale 1ns/1ps
// Module bus_recovery_seq
// Controller-side two-wire bus recovery: on start_req it emits a start,
// nine dummy SCL clocks with SDA released, a second start and a stop, then
// leaves both lines released. Outputs are open-drain pull-low enables.
// Assumes HALF_PERIOD >= 2 system clocks per SCL half-period.
module bus_recovery_seq
    import busrec_pkg::*;
#(
    parameter int HALF_PERIOD = 250,
    parameter int NUM_CLOCKS  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    output logic busy,
    output logic done,
    output logic scl_pull,
    output logic sda_pull
);
    rec_state_e state_q;
    rec_state_e state_d;
    logic       tick;

    // Busy covers every phase other than idle.
    assign busy = (state_q != ST_IDLE);

    half_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    recovery_fsm #(.NUM_CLOCKS(NUM_CLOCKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .tick      (tick),
        .state_q   (state_q),
        .state_d   (state_d),
        .done      (done)
    );

    line_driver u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_d  (state_d),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull)
    );
endmodule

// File: rtl/bus_recovery_chk.sv
`timescale 1ns/1ps
// Module bus_recovery_chk
// Protocol checker bound to bus_recovery_seq. It tracks how long the line
// drive has been steady, so minimum phase length is checked without a long
// $past window. Assumes the synchronous active-low reset of the block.
module bus_recovery_chk #(
    parameter int HALF_PERIOD = 250
) (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic busy,
    input logic done,
    input logic scl_pull,
    input logic sda_pull
);
    localparam int HOLD_W = $clog2(HALF_PERIOD + 1);
    localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HALF_PERIOD);
    localparam logic [HOLD_W-1:0] HOLD_MIN = HOLD_W'(HALF_PERIOD - 1);

    logic              scl_q;
    logic              sda_q;
    logic [HOLD_W-1:0] hold_cnt;
    logic              line_moved;

    assign line_moved = (scl_pull != scl_q) || (sda_pull != sda_q);

    // Track the previous drive and how many cycles it has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q    <= 1'b0;
            sda_q    <= 1'b0;
            hold_cnt <= HOLD_MAX;
        end else begin
            scl_q    <= scl_pull;
            sda_q    <= sda_pull;
            if (line_moved)              hold_cnt <= '0;
            else if (hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // R1: idle means both lines released
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull));

    // R2: busy only rises after a request
    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req));

    // R5: never move both lines in one cycle
    p_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_pull) |-> $stable(sda_pull));

    // R5: every drive level is held for a full half-period
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_moved |-> (hold_cnt >= HOLD_MIN));

    // R8: done coincides with busy low
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bus_recovery_seq bus_recovery_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .busy      (busy),
    .done      (done),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull)
);

// File: tb/tb_bus_recovery_seq.sv
`timescale 1ns/1ps
// Bench for bus_recovery_seq: walks a table of expected line drive per
// phase, then directed tests for reset, busy requests and mid-run reset.
module tb_bus_recovery_seq;
    localparam int HP      = 4;
    localparam int NPH     = 23;
    localparam int SEQ_CYC = NPH * HP;

    // Expected {scl_pull, sda_pull} per half-period phase.
    localparam logic [1:0] EXP_TAB [NPH] = '{
        2'b00, 2'b01, 2'b11,
        2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00,
        2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00,
        2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00,
        2'b01, 2'b00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic busy, done, scl_pull, sda_pull;
    int   n_chk = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    bus_recovery_seq #(.HALF_PERIOD(HP)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .busy(busy), .done(done), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    function automatic string phase_req(int p);
        if (p == 0) return "R2";
        if (p <= 2) return "R3";
        if (p == 21) return "R6";
        if (p == 22) return "R7";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Run one full sequence; noisy adds requests while busy (R9).
    task automatic run_sequence(input bit noisy);
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        for (int c = 0; c < SEQ_CYC; c++) begin
            check(busy === 1'b1, "R8", "busy during sequence", busy, 1);
            check({scl_pull, sda_pull} === EXP_TAB[c / HP], phase_req(c / HP),
                  "line drive", {scl_pull, sda_pull}, EXP_TAB[c / HP]);
            check(done === 1'b0, "R8", "done early", done, 0);
            if (noisy) start_req = (c == 5) || (c == 40) || (c == SEQ_CYC - 1);
            @(negedge clk);
        end
        start_req = 1'b0;
        check(done === 1'b1, "R8", "done pulse", done, 1);
        check(busy === 1'b0, "R8", "busy with done", busy, 0);
        check({scl_pull, sda_pull} === 2'b00, "R7", "released after stop",
              {scl_pull, sda_pull}, 0);
        @(negedge clk);
        check(done === 1'b0, "R8", "done width", done, 0);
        check(busy === 1'b0, "R9", "no queued restart", busy, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({busy, done, scl_pull, sda_pull} === 4'b0000, "R1", "in reset",
              {busy, done, scl_pull, sda_pull}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, scl_pull, sda_pull} === 4'b0000, "R1", "idle",
              {busy, done, scl_pull, sda_pull}, 0);

        run_sequence(1'b0);
        run_sequence(1'b1);   // R9

        // R10: reset in the middle of the dummy clocks
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        repeat (30) @(negedge clk);
        check(busy === 1'b1, "R10", "busy before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check({busy, done, scl_pull, sda_pull} === 4'b0000, "R10",
              "mid-run reset", {busy, done, scl_pull, sda_pull}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, scl_pull, sda_pull} === 4'b0000, "R10",
              "idle after reset", {busy, done, scl_pull, sda_pull}, 0);

        run_sequence(1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule